// File: doc/BRIEF.md
# Variable-Page Data TLB Lookup

This block translates 32-bit virtual data addresses into physical addresses through a fully associative table of page entries. Each entry carries its own page size: 1 KB, 4 KB, 64 KB or 1 MB. It applies user/privileged protection and write permission, and it reports the first store to a clean page as a separate fault. Some fixed address windows skip translation. In user mode most of those windows are refused as address errors. When translation is switched off, the block passes the low 29 address bits straight through.

A lookup is presented for one cycle on the request inputs. The outcome is either a physical address or a 12-bit fault code. It is registered and appears on the next clock edge, together with a one-cycle done strobe. On a fault the block records two things: the full faulting address, and (for every fault except a multiple hit) the faulting virtual page number. A table-entry write port loads one entry per cycle by index. A round-robin replacement counter, with a programmable upper bound, steps on every lookup that consults the table. It gives the index a refill routine should use next.

Top module: `utlb_xlate`

## Requirements
- R1: When `req_vld` is high, the result appears on the next rising edge with `rsp_done` high for exactly that one cycle. When `req_vld` is low, `rsp_done` is low on the next edge.
- R2: The page size code selects the page: 0 gives 1 KB, 1 gives 4 KB, 2 gives 64 KB and 3 gives 1 MB. The virtual page number is compared only above that page boundary. On a hit, the entry's physical page number replaces the address bits above the boundary, and the offset bits below it are copied unchanged.
- R3: Only valid entries can match. A non-shared entry must also carry the ASID `cur_asid`. ASID checking is switched off only when `single_vm` and `priv` are both high.
- R4: Two or more matching entries give fault code 0x140. No matching entry gives 0x040 for a load and 0x060 for a store.
- R5: A user access (`priv` low) to an entry whose protection bit 1 is 0 gives 0x0A0 for a load and 0x0C0 for a store. A store that passes that test but hits an entry whose protection bit 0 is 0 gives 0x0C0.
- R6: A store that passes both protection tests but hits an entry whose dirty bit is 0 gives 0x080.
- R7: Addresses 0x80000000 to 0xBFFFFFFF skip the table and map to their low 29 bits. Addresses 0xE0000000 and above skip the table unchanged.
- R8: A user access to a skip window gives an address error, unless the address lies in 0xE0000000 to 0xE3FFFFFF. The code is 0x0E0 for a load and 0x100 for a store.
- R9: With `mmu_on` low, any address outside the skip windows maps to its low 29 bits with no fault, and the replacement counter does not move.
- R10: `repl_ctr` increments on every registered lookup that consults the table. It returns to 0 when the incremented value would exceed a nonzero `repl_limit`, or would exceed ENTRIES-1. It does not move otherwise.
- R11: `fault_addr` takes the full virtual address on every fault. `pte_hi_vpn` takes address bits 31:10 on every fault except 0x140, and keeps its value on a 0x140 fault.
- R12: An entry written through the write port can be matched from the following cycle on. A lookup in the same cycle as the write still sees the previous contents.
- R13: After reset, `rsp_done`, `fault_addr`, `pte_hi_vpn` and `repl_ctr` are 0, and no entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Lookup request, one cycle |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| cur_asid | input | 8 | Current address-space identifier |
| priv | input | 1 | Privileged mode |
| mmu_on | input | 1 | Translation enable |
| single_vm | input | 1 | Single-virtual-space mode |
| repl_limit | input | 6 | Upper bound for replacement counter (0 = none) |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 6 | Entry index to write |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_ppn | input | 19 | Physical page number (address bits 28:10) |
| wr_asid | input | 8 | Entry ASID |
| wr_valid | input | 1 | Entry valid |
| wr_shared | input | 1 | Entry shared across ASIDs |
| wr_size | input | 2 | Page size code |
| wr_prot | input | 2 | Protection: bit 1 user access, bit 0 write allowed |
| wr_dirty | input | 1 | Page dirty |
| rsp_done | output | 1 | Result valid strobe |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 12 | Fault code, 0 when no fault |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| fault_addr | output | 32 | Last faulting virtual address |
| pte_hi_vpn | output | 22 | Last faulting page number |
| repl_ctr | output | 6 | Replacement counter |

## Verification
The write port and the lookup can act in the same cycle, even on the same entry. The bench drives a write of a fresh entry and a lookup of that entry's address on one clock. The expected result is a miss built from the old table contents, and a repeat lookup one cycle later must hit. A second overlap is a lookup that faults while it also steps the replacement counter. The bench judges both the recorded fault state and the counter against its own model on every clock.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int VPN_W  = 22;
  localparam int PPN_W  = 19;
  localparam int ASID_W = 8;
  localparam int CODE_W = 12;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [ASID_W-1:0] asid;
    logic              valid;
    logic              shared;
    logic [1:0]        size;
    logic [1:0]        prot;
    logic              dirty;
  } tlb_ent_t;

  localparam logic [CODE_W-1:0] C_NONE    = 12'h000;
  localparam logic [CODE_W-1:0] C_MISS_R  = 12'h040;
  localparam logic [CODE_W-1:0] C_MISS_W  = 12'h060;
  localparam logic [CODE_W-1:0] C_INIT_W  = 12'h080;
  localparam logic [CODE_W-1:0] C_VIOL_R  = 12'h0A0;
  localparam logic [CODE_W-1:0] C_VIOL_W  = 12'h0C0;
  localparam logic [CODE_W-1:0] C_AERR_R  = 12'h0E0;
  localparam logic [CODE_W-1:0] C_AERR_W  = 12'h100;
  localparam logic [CODE_W-1:0] C_MULTI   = 12'h140;

  // VPN bits that fall inside the page offset for a given size code
  function automatic logic [VPN_W-1:0] pg_lo_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    return '0;
      2'd1:    return 22'h3;
      2'd2:    return 22'h3F;
      default: return 22'h3FF;
    endcase
  endfunction
endpackage

// File: rtl/utlb_entry_array.sv
module utlb_entry_array
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  tlb_ent_t          wr_ent,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              asid_chk,
  output logic              any_hit,
  output logic              multi_hit,
  output tlb_ent_t          sel_ent
);
  logic [ENTRIES-1:0] hit_vec;
  tlb_ent_t           ent_rd [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic     v_q;
    tlb_ent_t d_q;
    logic     wr_me;
    logic [VPN_W-1:0] cmp_mask;

    assign wr_me = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     v_q <= 1'b0;
      else if (wr_me) v_q <= wr_ent.valid;
    end

    always_ff @(posedge clk) begin
      if (wr_me) d_q <= wr_ent;
    end

    assign cmp_mask = ~pg_lo_bits(d_q.size);
    assign hit_vec[g] = v_q
                     && (d_q.shared || !asid_chk || (d_q.asid == lk_asid))
                     && ((d_q.vpn & cmp_mask) == (lk_vpn & cmp_mask));
    assign ent_rd[g] = d_q;
  end

  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) sel_ent = sel_ent | ent_rd[i];
    end
  end

  assign any_hit   = |hit_vec;
  assign multi_hit = |(hit_vec & (hit_vec - 1'b1));

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && !multi_hit) |-> $onehot(hit_vec)); // R4
endmodule

// File: rtl/utlb_repl_ctr.sv
module utlb_repl_ctr #(
  parameter int ENTRIES = 64,
  localparam int W      = $clog2(ENTRIES)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic [W-1:0] ctr
);
  localparam logic [W:0] TOP = (W+1)'(ENTRIES - 1);

  logic [W-1:0] ctr_q, ctr_nx;
  logic [W:0]   inc;

  always_comb begin
    inc    = {1'b0, ctr_q} + 1'b1;
    ctr_nx = inc[W-1:0];
    if (((limit != '0) && (inc > {1'b0, limit})) || (inc > TOP)) ctr_nx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctr_q <= '0;
    else if (step) ctr_q <= ctr_nx;
  end

  assign ctr = ctr_q;

  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ctr)); // R10
  AST_CTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (ctr == '1)) |=> (ctr == '0)); // R10
endmodule

// File: rtl/utlb_xlate.sv
module utlb_xlate
  import utlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_vld,
  input  logic [31:0]         req_vaddr,
  input  logic                req_store,
  input  logic [ASID_W-1:0]   cur_asid,
  input  logic                priv,
  input  logic                mmu_on,
  input  logic                single_vm,
  input  logic [IDX_W-1:0]    repl_limit,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic                wr_valid,
  input  logic                wr_shared,
  input  logic [1:0]          wr_size,
  input  logic [1:0]          wr_prot,
  input  logic                wr_dirty,
  output logic                rsp_done,
  output logic                rsp_fault,
  output logic [CODE_W-1:0]   rsp_code,
  output logic [31:0]         rsp_paddr,
  output logic [31:0]         fault_addr,
  output logic [VPN_W-1:0]    pte_hi_vpn,
  output logic [IDX_W-1:0]    repl_ctr
);
  tlb_ent_t wr_ent, sel_ent;
  logic     any_hit, multi_hit, asid_chk;
  logic     in_p12, in_p4, in_sq, bypass;
  logic     nx_fault, tbl_access;
  logic [CODE_W-1:0] nx_code;
  logic [31:0]       nx_paddr, off_mask;

  assign wr_ent = '{vpn: wr_vpn, ppn: wr_ppn, asid: wr_asid, valid: wr_valid,
                    shared: wr_shared, size: wr_size, prot: wr_prot, dirty: wr_dirty};
  assign asid_chk = !(single_vm && priv);

  utlb_entry_array #(.ENTRIES(ENTRIES)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .lk_vpn(req_vaddr[31:10]), .lk_asid(cur_asid), .asid_chk(asid_chk),
    .any_hit(any_hit), .multi_hit(multi_hit), .sel_ent(sel_ent)
  );

  utlb_repl_ctr #(.ENTRIES(ENTRIES)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step(req_vld && tbl_access),
    .limit(repl_limit), .ctr(repl_ctr)
  );

  assign in_p12  = (req_vaddr[31:30] == 2'b10);
  assign in_p4   = (req_vaddr[31:29] == 3'b111);
  assign in_sq   = (req_vaddr[31:26] == 6'b111000);
  assign bypass  = in_p12 || in_p4;
  assign off_mask = {pg_lo_bits(sel_ent.size), 10'h3FF};

  // next-state: classify the request
  always_comb begin
    nx_fault   = 1'b0;
    nx_code    = C_NONE;
    nx_paddr   = '0;
    tbl_access = 1'b0;
    if (bypass) begin
      if (!priv && !in_sq) begin
        nx_fault = 1'b1;
        nx_code  = req_store ? C_AERR_W : C_AERR_R;
      end else begin
        nx_paddr = in_p12 ? {3'b000, req_vaddr[28:0]} : req_vaddr;
      end
    end else if (!mmu_on) begin
      nx_paddr = {3'b000, req_vaddr[28:0]};
    end else begin
      tbl_access = 1'b1;
      nx_fault   = 1'b1;
      if (multi_hit)                          nx_code = C_MULTI;
      else if (!any_hit)                      nx_code = req_store ? C_MISS_W : C_MISS_R;
      else if (!priv && !sel_ent.prot[1])     nx_code = req_store ? C_VIOL_W : C_VIOL_R;
      else if (req_store && !sel_ent.prot[0]) nx_code = C_VIOL_W;
      else if (req_store && !sel_ent.dirty)   nx_code = C_INIT_W;
      else begin
        nx_fault = 1'b0;
        nx_paddr = ({3'b000, sel_ent.ppn, 10'h000} & ~off_mask) | (req_vaddr & off_mask);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done   <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_code   <= C_NONE;
      rsp_paddr  <= '0;
      fault_addr <= '0;
      pte_hi_vpn <= '0;
    end else begin
      rsp_done <= req_vld;
      if (req_vld) begin
        rsp_fault <= nx_fault;
        rsp_code  <= nx_code;
        rsp_paddr <= nx_paddr;
      end
      if (req_vld && nx_fault) begin
        fault_addr <= req_vaddr;
        if (nx_code != C_MULTI) pte_hi_vpn <= req_vaddr[31:10];
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_done); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_done); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !nx_fault) |=> (rsp_paddr[9:0] == $past(req_vaddr[9:0]))); // R2
  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault) |-> (fault_addr == $past(req_vaddr))); // R11
  AST_MULTI_KEEPS_PTE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault && rsp_code == C_MULTI) |-> $stable(pte_hi_vpn)); // R11
endmodule

// File: tb/utlb_xlate_tb.sv
module utlb_xlate_tb;
  localparam int N = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_vld, req_store, priv, mmu_on, single_vm;
  logic [31:0] req_vaddr;
  logic [7:0] cur_asid, wr_asid;
  logic [5:0] repl_limit, wr_idx, repl_ctr;
  logic wr_en, wr_valid, wr_shared, wr_dirty;
  logic [21:0] wr_vpn, pte_hi_vpn;
  logic [18:0] wr_ppn;
  logic [1:0] wr_size, wr_prot;
  logic rsp_done, rsp_fault;
  logic [11:0] rsp_code;
  logic [31:0] rsp_paddr, fault_addr;

  utlb_xlate #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_vaddr(req_vaddr),
    .req_store(req_store), .cur_asid(cur_asid), .priv(priv), .mmu_on(mmu_on),
    .single_vm(single_vm), .repl_limit(repl_limit), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_asid(wr_asid), .wr_valid(wr_valid),
    .wr_shared(wr_shared), .wr_size(wr_size), .wr_prot(wr_prot), .wr_dirty(wr_dirty),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .fault_addr(fault_addr), .pte_hi_vpn(pte_hi_vpn),
    .repl_ctr(repl_ctr)
  );

  // behavioural reference state
  logic [21:0] m_vpn [N];
  logic [18:0] m_ppn [N];
  logic [7:0]  m_asid [N];
  bit          m_v [N], m_sh [N], m_d [N];
  logic [1:0]  m_sz [N], m_pr [N];
  int          m_ctr;
  logic [31:0] m_fa;
  logic [21:0] m_pte;
  bit          e_done, e_fault;
  logic [11:0] e_code;
  logic [31:0] e_paddr;
  int          nvec = 0, nbad = 0;
  string       tag;

  task automatic mdl(output bit f, output logic [11:0] c, output logic [31:0] pa, output bit acc);
    longint unsigned a, sz, st, ph;
    int nm, hit;
    bit chk;
    a = longint'(req_vaddr);
    f = 0; c = 12'h000; pa = 32'h0; acc = 0;
    if ((a >= 64'h8000_0000 && a < 64'hC000_0000) || a >= 64'hE000_0000) begin
      if (!priv && (a < 64'hE000_0000 || a >= 64'hE400_0000)) begin
        f = 1; c = req_store ? 12'h100 : 12'h0E0;
      end else if (a < 64'hC000_0000) pa = 32'(a % 64'h2000_0000);
      else pa = 32'(a);
    end else if (!mmu_on) begin
      pa = 32'(a % 64'h2000_0000);
    end else begin
      acc = 1; nm = 0; hit = 0;
      chk = !(single_vm && priv);
      for (int i = 0; i < N; i++) begin
        if (!m_v[i]) continue;
        if (!m_sh[i] && chk && m_asid[i] != cur_asid) continue;
        sz = 64'd1024 << ((m_sz[i] == 0) ? 0 : (m_sz[i] == 1) ? 2 : (m_sz[i] == 2) ? 6 : 10);
        st = (longint'(m_vpn[i]) * 1024) & ~(sz - 1);
        if (a >= st && a <= st + sz - 1) begin nm++; hit = i; end
      end
      f = 1;
      if (nm > 1) c = 12'h140;
      else if (nm == 0) c = req_store ? 12'h060 : 12'h040;
      else if (!priv && !m_pr[hit][1]) c = req_store ? 12'h0C0 : 12'h0A0;
      else if (req_store && !m_pr[hit][0]) c = 12'h0C0;
      else if (req_store && !m_d[hit]) c = 12'h080;
      else begin
        f = 0;
        sz = 64'd1024 << ((m_sz[hit] == 0) ? 0 : (m_sz[hit] == 1) ? 2 : (m_sz[hit] == 2) ? 6 : 10);
        st = (longint'(m_vpn[hit]) * 1024) & ~(sz - 1);
        ph = (longint'(m_ppn[hit]) * 1024) & ~(sz - 1);
        pa = 32'(ph + (a - st));
      end
    end
  endtask

  task automatic tick();
    bit f, acc, bad;
    logic [11:0] c;
    logic [31:0] pa;
    mdl(f, c, pa, acc);
    e_done = req_vld;
    if (req_vld) begin
      e_fault = f; e_code = c; e_paddr = pa;
      if (f) begin
        m_fa = req_vaddr;
        if (c != 12'h140) m_pte = req_vaddr[31:10];
      end
      if (acc) begin
        m_ctr++;
        if ((repl_limit != 0 && m_ctr > int'(repl_limit)) || m_ctr > N - 1) m_ctr = 0;
      end
    end
    if (wr_en) begin
      m_vpn[wr_idx] = wr_vpn; m_ppn[wr_idx] = wr_ppn; m_asid[wr_idx] = wr_asid;
      m_v[wr_idx] = wr_valid; m_sh[wr_idx] = wr_shared; m_sz[wr_idx] = wr_size;
      m_pr[wr_idx] = wr_prot; m_d[wr_idx] = wr_dirty;
    end
    @(posedge clk);
    @(negedge clk);
    nvec++; bad = 0;
    if (rsp_done !== e_done) begin
      $display("FAIL %s done actual=%0b expected=%0b", tag, rsp_done, e_done); bad = 1;
    end
    if (e_done) begin
      if (rsp_fault !== e_fault) begin
        $display("FAIL %s fault actual=%0b expected=%0b", tag, rsp_fault, e_fault); bad = 1;
      end
      if (rsp_code !== e_code) begin
        $display("FAIL %s code actual=%h expected=%h", tag, rsp_code, e_code); bad = 1;
      end
      if (rsp_paddr !== e_paddr) begin
        $display("FAIL %s paddr actual=%h expected=%h", tag, rsp_paddr, e_paddr); bad = 1;
      end
    end
    if (fault_addr !== m_fa) begin
      $display("FAIL %s fault_addr actual=%h expected=%h", tag, fault_addr, m_fa); bad = 1;
    end
    if (pte_hi_vpn !== m_pte) begin
      $display("FAIL %s pte_hi_vpn actual=%h expected=%h", tag, pte_hi_vpn, m_pte); bad = 1;
    end
    if (int'(repl_ctr) != m_ctr) begin
      $display("FAIL %s repl_ctr actual=%0d expected=%0d", tag, repl_ctr, m_ctr); bad = 1;
    end
    if (bad) nbad++;
    req_vld = 0; wr_en = 0;
  endtask

  task automatic wr(input int idx, input logic [21:0] vpn, input logic [18:0] ppn,
                    input logic [7:0] asid, input bit v, input bit sh,
                    input logic [1:0] sz, input logic [1:0] pr, input bit d);
    wr_en = 1; wr_idx = 6'(idx); wr_vpn = vpn; wr_ppn = ppn; wr_asid = asid;
    wr_valid = v; wr_shared = sh; wr_size = sz; wr_prot = pr; wr_dirty = d;
  endtask

  task automatic lk(input logic [31:0] a, input bit st, input bit pv, input string t);
    req_vld = 1; req_vaddr = a; req_store = st; priv = pv; tag = t;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL R1 watchdog actual=running expected=finished");
    nbad++;
    finish_run();
  end

  initial begin
    rst_n = 0; req_vld = 0; req_vaddr = 0; req_store = 0; cur_asid = 8'd5;
    priv = 0; mmu_on = 1; single_vm = 0; repl_limit = 0;
    wr_en = 0; wr_idx = 0; wr_vpn = 0; wr_ppn = 0; wr_asid = 0;
    wr_valid = 0; wr_shared = 0; wr_size = 0; wr_prot = 0; wr_dirty = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_ctr = 0; m_fa = 0; m_pte = 0; e_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R13 idle after reset"; tick();
    lk(32'h0040_0000, 0, 1, "R13 empty table miss"); tick();

    // table contents
    wr(0, 22'h01000, 19'h00123, 8'd5, 1, 0, 2'd0, 2'b11, 1); tag = "R12 load e0"; tick();
    wr(1, 22'h40000, 19'h00200, 8'd5, 1, 0, 2'd1, 2'b10, 1); tag = "R12 load e1"; tick();
    wr(2, 22'h8003F, 19'h01000, 8'd9, 1, 1, 2'd2, 2'b11, 0); tag = "R12 load e2"; tick();
    wr(3, 22'hC03FF, 19'h04000, 8'd5, 1, 0, 2'd3, 2'b00, 1); tag = "R12 load e3"; tick();
    wr(4, 22'h140000, 19'h00300, 8'd5, 1, 0, 2'd1, 2'b11, 1); tag = "R12 load e4"; tick();
    wr(5, 22'h140000, 19'h00400, 8'd5, 1, 0, 2'd1, 2'b11, 1); tag = "R12 load e5"; tick();
    wr(6, 22'h180000, 19'h00500, 8'd5, 0, 0, 2'd1, 2'b11, 1); tag = "R12 load e6"; tick();
    wr(7, 22'h1C0000, 19'h00600, 8'd7, 1, 0, 2'd1, 2'b11, 1); tag = "R12 load e7"; tick();

    lk(32'h0040_02A4, 0, 0, "R2 1K hit"); tick();
    lk(32'h0040_05A4, 0, 0, "R2 R4 past 1K boundary miss load"); tick();
    lk(32'h1000_0FFC, 0, 0, "R2 4K hit"); tick();
    lk(32'h1000_0010, 1, 0, "R5 store to write-protected page"); tick();
    lk(32'h2000_ABCD, 0, 0, "R2 R3 64K shared hit"); tick();
    lk(32'h2000_ABCD, 1, 1, "R6 clean page store"); tick();
    lk(32'h300F_1234, 0, 0, "R5 user load no user access"); tick();
    lk(32'h300F_1234, 1, 0, "R5 user store no user access"); tick();
    lk(32'h300F_1234, 0, 1, "R2 1M privileged hit"); tick();
    lk(32'h300F_1234, 1, 1, "R5 privileged store read-only"); tick();
    lk(32'h5000_0040, 0, 1, "R4 R11 multiple hit"); tick();
    lk(32'h6000_0000, 1, 1, "R3 R4 invalid entry store miss"); tick();
    lk(32'h7000_0100, 0, 1, "R3 ASID mismatch"); tick();
    single_vm = 1;
    lk(32'h7000_0100, 0, 1, "R3 single-vm privileged ignores ASID"); tick();
    lk(32'h7000_0100, 0, 0, "R3 single-vm user checks ASID"); tick();
    single_vm = 0;

    lk(32'h8ABC_DEF0, 0, 1, "R7 low window masked"); tick();
    lk(32'hA123_4567, 1, 1, "R7 second low window masked"); tick();
    lk(32'hFF00_1000, 0, 1, "R7 top window unchanged"); tick();
    lk(32'hE200_0000, 1, 0, "R8 user allowed window"); tick();
    lk(32'hE400_0000, 0, 0, "R8 user address error load"); tick();
    lk(32'h9000_0000, 1, 0, "R8 user address error store"); tick();
    lk(32'hC000_0000, 0, 1, "R7 R4 window gap goes to table"); tick();

    mmu_on = 0;
    lk(32'h7FFF_FFFF, 0, 0, "R9 off user"); tick();
    lk(32'hD000_0004, 1, 1, "R9 off privileged store"); tick();
    mmu_on = 1;

    // same-cycle write and lookup
    wr(8, 22'h20000, 19'h00700, 8'd5, 1, 0, 2'd1, 2'b11, 1);
    lk(32'h0800_0123, 0, 0, "R12 lookup during write sees old"); tick();
    lk(32'h0800_0123, 0, 0, "R12 lookup after write hits"); tick();

    // counter wrap at table size, then at a bound
    for (int i = 0; i < 70; i++) begin
      lk(32'h0040_0000 + 32'(i), 0, 0, "R10 count to table size"); tick();
    end
    repl_limit = 6'd5;
    for (int i = 0; i < 12; i++) begin
      lk(32'h1000_0000, i[0], 0, "R10 bounded wrap"); tick();
    end
    tag = "R1 idle no strobe"; tick();
    finish_run();
  end
endmodule